// File: doc/BRIEF.md
# Color Palette Index/Data Port

This block gives a processor indirect byte access to a shared color palette memory. The memory holds two sets of colors: one for backgrounds and one for objects. Each set holds eight palettes of four 16-bit colors. The processor reaches each set through two registers. A selector register picks one byte of the set, and a data register reads or writes that byte. Colors are stored little-endian: an even byte index addresses the low half of a color, and an odd index addresses the high half.

The selector can advance by one byte after each data write, so a whole palette can be loaded as a run of data writes. The data register is a real register. Whenever the selector moves, whether by a direct write or by an advance, the register is reloaded with the byte the selector now points at. A separate combinational read port lets the display pipeline fetch a full 16-bit color from each set by palette number and color number.

Top module: `pal_port`

## Requirements
- R1: After reset, both selectors read 0x40 (index 0, advance off) and both data registers read 0x00. Every stored color is 0x0000.
- R2: Register choice uses `cpu_sel`: bit 1 picks the set (0 background, 1 object) and bit 0 picks the register (0 selector, 1 data). A selector reads back with bit 7 holding the advance flag, bit 6 always 1, and bits 5:0 holding the byte index.
- R3: A data write stores the byte into color entry index/2. An even index writes bits 7:0 of the color, and an odd index writes bits 15:8.
- R4: Writing a selector reloads that set's data register with the stored byte at the new index.
- R5: When the advance flag is set, a data write moves the index up by one and reloads the data register from the byte at the new index.
- R6: An advance from index 63 wraps to index 0.
- R7: When the advance flag is clear, a data write leaves the index unchanged, and the data register then reads the byte just written.
- R8: Object colors occupy entries 32 to 63 of the shared store and background colors occupy entries 0 to 31. A write to one set never changes the colors of the other set.
- R9: The display port returns the 16-bit color at entry palette*4 + color of its set, combinationally, including the unused bit 15.
- R10: Bit 6 of a selector write is ignored, and the selector still reads back with bit 6 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_we | input | 1 | Byte write strobe |
| cpu_sel | input | 2 | Register select: bit 1 set, bit 0 selector/data |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte of the selected register (combinational) |
| bg_pal | input | 3 | Background palette number for the display read |
| bg_col | input | 2 | Background color number for the display read |
| bg_color | output | 16 | Background color for the display |
| ob_pal | input | 3 | Object palette number for the display read |
| ob_col | input | 2 | Object color number for the display read |
| ob_color | output | 16 | Object color for the display |

## Verification
The bench builds the block with its default parameters: eight palettes of four colors per set, a 6-bit byte index, and 64 entries in the shared store. With these values the wrap from index 63 to 0 takes only a few writes to reach. The top of the object set lands on the last entry of the store, so a single run of writes exercises the set offset, bit 15 of a color and the wrap together. A short table of register accesses covers reload, advance and hold. Directed display reads then confirm entry placement and that the two sets stay separate.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int unsigned DEF_PALS   = 8;
  localparam int unsigned DEF_COLORS = 4;
  localparam int unsigned DEF_CW     = 16;
  localparam int unsigned SETS       = 2;

  typedef enum logic {REG_SELECTOR = 1'b0, REG_DATA = 1'b1} reg_kind_e;
endpackage

// File: rtl/pal_index_unit.sv
module pal_index_unit #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_wr,
  input  logic             data_wr,
  input  logic [7:0]       wdata,
  output logic [IDX_W-1:0] idx_q,
  output logic             inc_q,
  output logic [IDX_W-1:0] idx_nxt,
  output logic             advance
);
  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i);
    return i + 1'b1;
  endfunction

  assign advance = data_wr && inc_q;

  always_comb begin
    idx_nxt = idx_q;
    if (sel_wr)       idx_nxt = wdata[IDX_W-1:0];
    else if (advance) idx_nxt = step(idx_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      inc_q <= 1'b0;
    end else begin
      idx_q <= idx_nxt;
      if (sel_wr) inc_q <= wdata[7];
    end
  end

  a_r5_step: assert property (@(posedge clk) disable iff (rst)
    (data_wr && inc_q && !sel_wr) |=> (idx_q == IDX_W'($past(idx_q) + 1'b1)));
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !inc_q && !sel_wr) |=> $stable(idx_q));
endmodule

// File: rtl/pal_color_store.sv
module pal_color_store #(
  parameter int unsigned ENT_W = 5,
  parameter int unsigned CW    = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [1:0]                wr_en,
  input  logic [1:0][ENT_W-1:0]     wr_ent,
  input  logic [1:0]                wr_hi,
  input  logic [1:0][7:0]           wr_byte,
  input  logic [1:0][ENT_W-1:0]     cpu_ent,
  output logic [1:0][CW-1:0]        cpu_word,
  input  logic [1:0][ENT_W-1:0]     disp_ent,
  output logic [1:0][CW-1:0]        disp_word
);
  localparam int unsigned PER_SET = 1 << ENT_W;

  logic [1:0][PER_SET-1:0][CW-1:0] mem_q;

  for (genvar s = 0; s < 2; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (rst) begin
        mem_q[s] <= '0;
      end else if (wr_en[s]) begin
        if (wr_hi[s]) mem_q[s][wr_ent[s]][CW-1:8] <= wr_byte[s][CW-9:0];
        else          mem_q[s][wr_ent[s]][7:0]    <= wr_byte[s];
      end
    end

    assign cpu_word[s]  = mem_q[s][cpu_ent[s]];
    assign disp_word[s] = mem_q[s][disp_ent[s]];

    a_r8_set_isolated: assert property (@(posedge clk) disable iff (rst)
      !wr_en[s] |=> $stable(mem_q[s]));
  end
endmodule

// File: rtl/pal_port.sv
module pal_port #(
  parameter int unsigned PALS   = pal_pkg::DEF_PALS,
  parameter int unsigned COLORS = pal_pkg::DEF_COLORS,
  parameter int unsigned CW     = pal_pkg::DEF_CW
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cpu_we,
  input  logic [1:0]  cpu_sel,
  input  logic [7:0]  cpu_wdata,
  output logic [7:0]  cpu_rdata,
  input  logic [2:0]  bg_pal,
  input  logic [1:0]  bg_col,
  output logic [15:0] bg_color,
  input  logic [2:0]  ob_pal,
  input  logic [1:0]  ob_col,
  output logic [15:0] ob_color
);
  import pal_pkg::*;

  localparam int unsigned PAL_W = $clog2(PALS);
  localparam int unsigned COL_W = $clog2(COLORS);
  localparam int unsigned ENT_W = PAL_W + COL_W;
  localparam int unsigned IDX_W = ENT_W + 1;

  function automatic logic [ENT_W-1:0] slot_of(input logic [PAL_W-1:0] p,
                                               input logic [COL_W-1:0] c);
    return {p, c};
  endfunction

  function automatic logic [7:0] pick_byte(input logic [CW-1:0] w, input logic hi);
    return hi ? w[CW-1:8] : w[7:0];
  endfunction

  logic [1:0]                sel_wr, data_wr, inc_q, advance;
  logic [1:0][IDX_W-1:0]     idx_q, idx_nxt;
  logic [1:0][7:0]           data_q;
  logic [1:0][ENT_W-1:0]     wr_ent, cpu_ent, disp_ent;
  logic [1:0]                wr_hi;
  logic [1:0][7:0]           wr_byte;
  logic [1:0][CW-1:0]        cpu_word, disp_word;

  for (genvar s = 0; s < 2; s++) begin : g_set
    assign sel_wr[s]  = cpu_we && (cpu_sel[1] == 1'(s)) && (cpu_sel[0] == REG_SELECTOR);
    assign data_wr[s] = cpu_we && (cpu_sel[1] == 1'(s)) && (cpu_sel[0] == REG_DATA);

    pal_index_unit #(.IDX_W(IDX_W)) u_idx (
      .clk(clk), .rst(rst),
      .sel_wr(sel_wr[s]), .data_wr(data_wr[s]), .wdata(cpu_wdata),
      .idx_q(idx_q[s]), .inc_q(inc_q[s]), .idx_nxt(idx_nxt[s]),
      .advance(advance[s])
    );

    assign wr_ent[s]  = idx_q[s][IDX_W-1:1];
    assign wr_hi[s]   = idx_q[s][0];
    assign wr_byte[s] = cpu_wdata;
    assign cpu_ent[s] = idx_nxt[s][IDX_W-1:1];

    always_ff @(posedge clk) begin
      if (rst)                          data_q[s] <= 8'h00;
      else if (sel_wr[s] || advance[s]) data_q[s] <= pick_byte(cpu_word[s], idx_nxt[s][0]);
      else if (data_wr[s])              data_q[s] <= cpu_wdata;
    end

    a_r4_reload: assert property (@(posedge clk) disable iff (rst)
      !(sel_wr[s] || data_wr[s]) |-> (data_q[s] == pick_byte(cpu_word[s], idx_q[s][0])));
  end

  assign disp_ent[0] = slot_of(bg_pal[PAL_W-1:0], bg_col[COL_W-1:0]);
  assign disp_ent[1] = slot_of(ob_pal[PAL_W-1:0], ob_col[COL_W-1:0]);

  pal_color_store #(.ENT_W(ENT_W), .CW(CW)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(data_wr), .wr_ent(wr_ent), .wr_hi(wr_hi), .wr_byte(wr_byte),
    .cpu_ent(cpu_ent), .cpu_word(cpu_word),
    .disp_ent(disp_ent), .disp_word(disp_word)
  );

  assign bg_color = 16'(disp_word[0]);
  assign ob_color = 16'(disp_word[1]);

  always_comb begin
    if (cpu_sel[0] == REG_SELECTOR)
      cpu_rdata = {inc_q[cpu_sel[1]], 1'b1, (6)'(idx_q[cpu_sel[1]])};
    else
      cpu_rdata = data_q[cpu_sel[1]];
  end
endmodule

// File: tb/pal_port_tb_top.sv
module pal_port_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_we = 1'b0;
  logic [1:0]  cpu_sel = 2'd0;
  logic [7:0]  cpu_wdata = 8'h00;
  logic [7:0]  cpu_rdata;
  logic [2:0]  bg_pal = 3'd0, ob_pal = 3'd0;
  logic [1:0]  bg_col = 2'd0, ob_col = 2'd0;
  logic [15:0] bg_color, ob_color;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pal_port dut_i (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .bg_pal(bg_pal), .bg_col(bg_col), .bg_color(bg_color),
    .ob_pal(ob_pal), .ob_col(ob_col), .ob_color(ob_color)
  );

  // {op (0 write, 1 read-check), sel, byte, expected}
  localparam logic [18:0] VEC [0:20] = '{
    {1'b0, 2'd0, 8'h80, 8'h00},  // bg selector idx0, advance on
    {1'b0, 2'd1, 8'h1F, 8'h00},  // R3 low byte entry0
    {1'b0, 2'd1, 8'h7C, 8'h00},  // R3 high byte entry0
    {1'b1, 2'd0, 8'h00, 8'hC2},  // R5 index advanced twice
    {1'b0, 2'd0, 8'h01, 8'h00},  // idx1, advance off
    {1'b1, 2'd1, 8'h00, 8'h7C},  // R4 reload
    {1'b0, 2'd1, 8'h55, 8'h00},
    {1'b1, 2'd0, 8'h00, 8'h41},  // R7 index held
    {1'b1, 2'd1, 8'h00, 8'h55},  // R7 data shows written byte
    {1'b0, 2'd0, 8'h00, 8'h00},
    {1'b1, 2'd1, 8'h00, 8'h1F},  // R4 reload even byte
    {1'b0, 2'd2, 8'hBE, 8'h00},  // obj idx62, advance on
    {1'b0, 2'd3, 8'h34, 8'h00},
    {1'b0, 2'd3, 8'h92, 8'h00},
    {1'b1, 2'd2, 8'h00, 8'hC0},  // R6 wrap to 0
    {1'b0, 2'd2, 8'h3F, 8'h00},
    {1'b1, 2'd3, 8'h00, 8'h92},  // R4 reload idx63
    {1'b1, 2'd2, 8'h00, 8'h7F},  // R2 format
    {1'b0, 2'd2, 8'h7E, 8'h00},
    {1'b1, 2'd2, 8'h00, 8'h7E},  // R10 bit6 ignored
    {1'b1, 2'd3, 8'h00, 8'h34}   // R4 reload idx62
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_sel = s; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] s, input logic [7:0] exp);
    @(negedge clk);
    cpu_sel = s;
    #1;
    check(req, {8'h00, cpu_rdata}, {8'h00, exp});
  endtask

  task automatic disp(input string req, input logic ob, input logic [2:0] p,
                      input logic [1:0] c, input logic [15:0] exp);
    @(negedge clk);
    if (ob) begin ob_pal = p; ob_col = c; end
    else    begin bg_pal = p; bg_col = c; end
    #1;
    check(req, ob ? ob_color : bg_color, exp);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd("R1", 2'd0, 8'h40);
    rd("R1", 2'd1, 8'h00);
    rd("R1", 2'd2, 8'h40);
    rd("R1", 2'd3, 8'h00);
    disp("R1", 1'b0, 3'd0, 2'd0, 16'h0000);

    for (int i = 0; i < 21; i++) begin
      if (VEC[i][18] == 1'b0) wr(VEC[i][17:16], VEC[i][15:8]);
      else rd("R2/R4/R5/R6/R7/R10 vector", VEC[i][17:16], VEC[i][7:0]);
    end

    // R9 display addressing, R3 byte order, R8 set separation
    disp("R9", 1'b0, 3'd0, 2'd0, 16'h551F);
    disp("R9", 1'b1, 3'd7, 2'd3, 16'h9234);
    disp("R8", 1'b0, 3'd7, 2'd3, 16'h0000);
    disp("R8", 1'b1, 3'd0, 2'd0, 16'h0000);

    wr(2'd0, 8'h92);          // bg idx18 (palette 2, color 1), advance on
    wr(2'd1, 8'hAB);
    wr(2'd1, 8'hCD);
    disp("R3", 1'b0, 3'd2, 2'd1, 16'hCDAB);
    disp("R9", 1'b0, 3'd2, 2'd0, 16'h0000);
    rd("R5", 2'd0, 8'hD4);
    report();
  end
endmodule